// File: doc/BRIEF.md
# Test Access Port Controller with User Scan Hooks

This block is a boundary-scan style test access port. A sixteen-state controller is stepped by the test clock and the mode-select line. It owns a three-bit instruction register, a one-flop bypass path, a 32-bit identifier register and a short internal stand-in boundary register. The stand-in exists only so that the pad-test and pad-sample instructions have a data register to scan. The test clock `tck` is the only clock of the block. The serial output changes on its falling edge and is qualified by an output-enable.

Two private instructions let logic outside the block build its own scan registers. While either one is current, a dedicated select line is high and the serial output is taken from the matching external scan-out pin. A gated data-register clock lets that logic shift in step with the port. An idle pin gives the NAND of the test clock and the Run-Test/Idle decode.

Top module: `tap_user_scan`

## Requirements
- R1: The controller moves between its sixteen states on each rising `tck` edge according to `tms`. Five rising edges with `tms` high reach Test-Logic-Reset from any state. A low `trst_n` forces Test-Logic-Reset at once, without a clock edge.
- R2: Entering or staying in Test-Logic-Reset makes BYPASS (3'b111) the current instruction. Otherwise the current instruction changes only on the rising edge that leaves Update-IR.
- R3: In Shift-IR the instruction register shifts least significant bit first. The value it captures is 3'b001, so the first three bits out are 1, 0, 0.
- R4: The bypass register is one flop that captures 0. In Shift-DR it delivers each `tdi` bit on `tdo` one `tck` later. The codes 3'b111, 3'b101 and 3'b110 all select it.
- R5: Code 3'b100 selects a 32-bit identifier register. It captures the parameter `IDCODE_VALUE` (default 32'h1C3A_5E27, bit 0 always 1) and shifts least significant bit first.
- R6: Codes 3'b000 and 3'b001 select the boundary stand-in, `PAD_CELLS`+3 bits long. Bits [2:0] sit nearest `tdo` and capture the reserved constant `RSV_BITS` (default 3'b110). The bits above them capture `pad_in`. The register shifts bit 0 first.
- R7: `user1_sel` is high exactly while 3'b010 is the current instruction. `user2_sel` is high exactly while 3'b011 is current.
- R8: In Shift-DR under 3'b010, `tdo` carries `user1_tdo`. Under 3'b011 it carries `user2_tdo`.
- R9: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is high only after a falling edge taken in Shift-IR or Shift-DR.
- R10: `user_drck` follows `tck` while a user instruction is current and the controller is in Capture-DR or Shift-DR. At all other times it is held high.
- R11: `idle_nand` equals NOT(`tck` AND the controller is in Run-Test/Idle).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Output-enable for tdo |
| pad_in | input | PAD_CELLS | Values captured into the boundary stand-in |
| user1_sel | output | 1 | First user instruction is current |
| user2_sel | output | 1 | Second user instruction is current |
| user1_tdo | input | 1 | Scan-out of the first user register |
| user2_tdo | input | 1 | Scan-out of the second user register |
| user_drck | output | 1 | Gated data-register clock for user scan logic |
| idle_nand | output | 1 | NAND of tck and the Run-Test/Idle decode |

## Verification
The hardest situation to reach is a reset that arrives while a user instruction is loaded and data is moving. In that case the select lines, the output-enable and the gated clock must all fall back together. The bench loads a user instruction, walks into Shift-DR, and then drops `trst_n` between clock edges. A second run instead applies five `tms`-high steps. Both observe the ports at once and again after the controller returns to Run-Test/Idle. Seeded random passes load all eight instruction codes with random data and pad values, so the rarely used unassigned codes and the register lengths are each checked against a bench model.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 3;

    localparam logic [IR_W-1:0] INS_EXTEST = 3'b000;
    localparam logic [IR_W-1:0] INS_SAMPLE = 3'b001;
    localparam logic [IR_W-1:0] INS_USER1  = 3'b010;
    localparam logic [IR_W-1:0] INS_USER2  = 3'b011;
    localparam logic [IR_W-1:0] INS_IDCODE = 3'b100;
    localparam logic [IR_W-1:0] INS_BYPASS = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [2:0] {
        DR_BYPASS, DR_IDCODE, DR_BSR, DR_USER1, DR_USER2
    } dr_sel_e;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: n = tms ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_q,
    output tap_state_e state_d
);

    typedef struct packed {
        tap_state_e state;
    } fsm_regs_t;

    fsm_regs_t regs_d, regs_q;

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = tap_next(regs_q.state, tms);
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) regs_q <= '{state: ST_TLR};
        else         regs_q <= regs_d;
    end

    assign state_q = regs_q.state;
    assign state_d = regs_d.state;

    // R1: holding tms high keeps the controller in reset
    assert_tlr_hold_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_TLR && tms) |=> (state_q == ST_TLR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_state_e      state_q,
    input  tap_state_e      state_d,
    output logic            ir_tdo,
    output dr_sel_e         dr_sel,
    output logic [IR_W-1:0] ins_cur
);

    typedef struct packed {
        logic [IR_W-1:0] sr;
        logic [IR_W-1:0] ins;
    } ir_regs_t;

    ir_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        case (state_q)
            ST_CAP_IR: regs_d.sr  = IR_CAPTURE;
            ST_SHF_IR: regs_d.sr  = {tdi, regs_q.sr[IR_W-1:1]};
            ST_UPD_IR: regs_d.ins = regs_q.sr;
            default: ;
        endcase
        if (state_d == ST_TLR) regs_d.ins = INS_BYPASS;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) regs_q <= '{sr: '0, ins: INS_BYPASS};
        else         regs_q <= regs_d;
    end

    always_comb begin
        case (regs_q.ins)
            INS_EXTEST, INS_SAMPLE: dr_sel = DR_BSR;
            INS_USER1:              dr_sel = DR_USER1;
            INS_USER2:              dr_sel = DR_USER2;
            INS_IDCODE:             dr_sel = DR_IDCODE;
            default:                dr_sel = DR_BYPASS;
        endcase
    end

    assign ir_tdo  = regs_q.sr[0];
    assign ins_cur = regs_q.ins;

    // R2: reset state always carries the bypass instruction
    assert_tlr_bypass_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_TLR) |-> (ins_cur == INS_BYPASS));

    // R2: instruction moves only when leaving Update-IR or entering reset
    assert_ins_stable_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q != ST_UPD_IR) |=> ($stable(ins_cur) || state_q == ST_TLR));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int              PAD_CELLS    = 5,
    parameter int              RSV_W        = 3,
    parameter logic [RSV_W-1:0] RSV_BITS    = 3'b110,
    parameter int              ID_W         = 32,
    parameter logic [ID_W-1:0] IDCODE_VALUE = 32'h1C3A_5E27
) (
    input  logic                 tck,
    input  logic                 trst_n,
    input  logic                 tdi,
    input  tap_state_e           state_q,
    input  dr_sel_e              dr_sel,
    input  logic [PAD_CELLS-1:0] pad_in,
    output logic                 dr_tdo
);

    localparam int BSR_W = PAD_CELLS + RSV_W;

    typedef struct packed {
        logic             bp;
        logic [ID_W-1:0]  id;
        logic [BSR_W-1:0] bsr;
    } dr_regs_t;

    dr_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (state_q == ST_CAP_DR) begin
            case (dr_sel)
                DR_BYPASS: regs_d.bp  = 1'b0;
                DR_IDCODE: regs_d.id  = IDCODE_VALUE;
                DR_BSR:    regs_d.bsr = {pad_in, RSV_BITS};
                default: ;
            endcase
        end else if (state_q == ST_SHF_DR) begin
            case (dr_sel)
                DR_BYPASS: regs_d.bp  = tdi;
                DR_IDCODE: regs_d.id  = {tdi, regs_q.id[ID_W-1:1]};
                DR_BSR:    regs_d.bsr = {tdi, regs_q.bsr[BSR_W-1:1]};
                default: ;
            endcase
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    always_comb begin
        case (dr_sel)
            DR_IDCODE: dr_tdo = regs_q.id[0];
            DR_BSR:    dr_tdo = regs_q.bsr[0];
            default:   dr_tdo = regs_q.bp;
        endcase
    end

    // R4: bypass captures zero
    assert_bypass_capture_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_CAP_DR && dr_sel == DR_BYPASS) |=> !regs_q.bp);

    // R4: one-flop delay of tdi while shifting bypass
    assert_bypass_delay_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_SHF_DR && dr_sel == DR_BYPASS) |=> (regs_q.bp == $past(tdi)));

    // R5: identifier always presents a set low bit after capture
    assert_idcode_lsb_R5: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_CAP_DR && dr_sel == DR_IDCODE) |=> regs_q.id[0]);

    // R6: reserved bits nearest the output after capture
    assert_rsv_capture_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_CAP_DR && dr_sel == DR_BSR) |=> (regs_q.bsr[RSV_W-1:0] == RSV_BITS));

endmodule

// File: rtl/tap_user_scan.sv
module tap_user_scan
    import tap_pkg::*;
#(
    parameter int               PAD_CELLS    = 5,
    parameter logic [2:0]       RSV_BITS     = 3'b110,
    parameter logic [31:0]      IDCODE_VALUE = 32'h1C3A_5E27
) (
    input  logic                 tck,
    input  logic                 trst_n,
    input  logic                 tms,
    input  logic                 tdi,
    output logic                 tdo,
    output logic                 tdo_oe,
    input  logic [PAD_CELLS-1:0] pad_in,
    output logic                 user1_sel,
    output logic                 user2_sel,
    input  logic                 user1_tdo,
    input  logic                 user2_tdo,
    output logic                 user_drck,
    output logic                 idle_nand
);

    tap_state_e      state_q, state_d;
    dr_sel_e         dr_sel;
    logic [IR_W-1:0] ins_cur;
    logic            ir_tdo, dr_tdo, scan_bit;

    tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms),
        .state_q(state_q), .state_d(state_d)
    );

    tap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .state_q(state_q), .state_d(state_d),
        .ir_tdo(ir_tdo), .dr_sel(dr_sel), .ins_cur(ins_cur)
    );

    tap_dr #(
        .PAD_CELLS(PAD_CELLS), .RSV_W(3), .RSV_BITS(RSV_BITS),
        .ID_W(32), .IDCODE_VALUE(IDCODE_VALUE)
    ) u_dr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .state_q(state_q), .dr_sel(dr_sel), .pad_in(pad_in),
        .dr_tdo(dr_tdo)
    );

    always_comb begin
        case (dr_sel)
            DR_USER1: scan_bit = user1_tdo;
            DR_USER2: scan_bit = user2_tdo;
            default:  scan_bit = dr_tdo;
        endcase
    end

    typedef struct packed {
        logic tdo;
        logic oe;
    } out_regs_t;

    out_regs_t out_d, out_q;

    always_comb begin
        out_d    = out_q;
        out_d.oe = (state_q == ST_SHF_IR) || (state_q == ST_SHF_DR);
        if (state_q == ST_SHF_IR)      out_d.tdo = ir_tdo;
        else if (state_q == ST_SHF_DR) out_d.tdo = scan_bit;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) out_q <= '0;
        else         out_q <= out_d;
    end

    logic user_active, drck_window;

    assign tdo         = out_q.tdo;
    assign tdo_oe      = out_q.oe;
    assign user1_sel   = (ins_cur == INS_USER1);
    assign user2_sel   = (ins_cur == INS_USER2);
    assign user_active = (dr_sel == DR_USER1) || (dr_sel == DR_USER2);
    assign drck_window = user_active && (state_q == ST_CAP_DR || state_q == ST_SHF_DR);
    assign user_drck   = drck_window ? tck : 1'b1;
    assign idle_nand   = ~(tck & (state_q == ST_RTI));

    // R9: enable seen at a rising edge implies a shift state
    assert_oe_in_shift_R9: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state_q == ST_SHF_IR || state_q == ST_SHF_DR));

    // R7: selects are cleared whenever the controller sits in reset
    assert_sel_clear_R7: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_TLR) |-> !(user1_sel || user2_sel));

endmodule

// File: tb/test_tap_user_scan.sv
`timescale 1ns/100ps
module test_tap_user_scan;

    localparam int          PADS  = 5;
    localparam logic [2:0]  RSV   = 3'b110;
    localparam logic [31:0] IDVAL = 32'h1C3A_5E27;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic [PADS-1:0] pad_in = '0;
    logic user1_tdo = 1'b0, user2_tdo = 1'b0;
    logic tdo, tdo_oe, user1_sel, user2_sel, user_drck, idle_nand;

    int n_checks = 0;
    int n_errors = 0;
    logic done = 1'b0;

    always #2.5 tck = ~tck;

    tap_user_scan #(.PAD_CELLS(PADS), .RSV_BITS(RSV), .IDCODE_VALUE(IDVAL)) i_tap_user_scan (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_oe(tdo_oe), .pad_in(pad_in),
        .user1_sel(user1_sel), .user2_sel(user2_sel),
        .user1_tdo(user1_tdo), .user2_tdo(user2_tdo),
        .user_drck(user_drck), .idle_nand(idle_nand)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one tck period: read outputs at low phase, drive inputs, pass rising edge
    task automatic step(input logic t, input logic d,
                        output logic o_tdo, output logic o_oe, output logic o_drck,
                        output logic o_tdo_hi);
        @(negedge tck); #1;
        o_tdo = tdo; o_oe = tdo_oe; o_drck = user_drck;
        tms = t; tdi = d;
        @(posedge tck); #1;
        o_tdo_hi = tdo;
    endtask

    task automatic go(input logic t);
        logic a, b, c, e;
        step(t, 1'b0, a, b, c, e);
    endtask

    task automatic shift_ir(input logic [2:0] code, output logic [2:0] cap);
        logic o, oe, dk, hi;
        go(1); go(1); go(0); go(0);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, code[i], o, oe, dk, hi);
            cap[i] = o;
            chk("R9 oe in Shift-IR", {63'd0, oe}, 64'd1);
        end
        go(1); go(0);
    endtask

    task automatic shift_dr(input int n, input logic [63:0] din, input logic user,
                            output logic [63:0] dout);
        logic o, oe, dk, hi;
        dout = '0;
        go(1); go(0);
        step(0, 1'b0, o, oe, dk, hi);
        chk("R10 drck in Capture-DR", {63'd0, dk}, {63'd0, !user});
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o, oe, dk, hi);
            dout[i] = o;
            if (i < 2) begin
                chk("R9 oe in Shift-DR", {63'd0, oe}, 64'd1);
                chk("R10 drck in Shift-DR", {63'd0, dk}, {63'd0, !user});
                chk("R9 tdo steady over rising edge", {63'd0, hi}, {63'd0, o});
            end
        end
        go(1); go(0);
    endtask

    function automatic logic [63:0] exp_dr(input logic [2:0] code, input logic [63:0] din,
                                           input int n, input logic [PADS-1:0] pads,
                                           input logic u1, input logic u2);
        logic [63:0] r;
        case (code)
            3'b000, 3'b001: r = {56'd0, pads, RSV};
            3'b010: r = u1 ? ((64'd1 << n) - 1) : 64'd0;
            3'b011: r = u2 ? ((64'd1 << n) - 1) : 64'd0;
            3'b100: r = {32'd0, IDVAL};
            default: r = (din << 1) & ((64'd1 << n) - 1);
        endcase
        return r;
    endfunction

    function automatic int dr_len(input logic [2:0] code);
        case (code)
            3'b000, 3'b001: return PADS + 3;
            3'b100:         return 32;
            3'b010, 3'b011: return 8;
            default:        return 12;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge tck);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [2:0]  cap;
        logic [63:0] din, dout;
        logic        o, oe, dk, hi;
        void'($urandom(32'd2718));

        #12;
        // reset state
        chk("R9 oe low in reset", {63'd0, tdo_oe}, 64'd0);
        chk("R7 sel1 low in reset", {63'd0, user1_sel}, 64'd0);
        chk("R7 sel2 low in reset", {63'd0, user2_sel}, 64'd0);
        chk("R10 drck high in reset", {63'd0, user_drck}, 64'd1);
        @(negedge tck); trst_n = 1'b1; tms = 1'b1;
        go(1); go(0);   // R1: TLR then RTI

        // R11 idle in Run-Test/Idle, both tck phases
        @(posedge tck); #1;
        chk("R11 idle with tck high in RTI", {63'd0, idle_nand}, 64'd0);
        @(negedge tck); #1;
        chk("R11 idle with tck low in RTI", {63'd0, idle_nand}, 64'd1);

        // R2 / R4: after reset the bypass path is selected
        din = 64'h0B5;
        shift_dr(8, din, 1'b0, dout);
        chk("R2 R4 bypass after reset", dout, exp_dr(3'b111, din, 8, pad_in, 1'b0, 1'b0));

        // R3 IR capture
        shift_ir(3'b100, cap);
        chk("R3 IR capture 001", {61'd0, cap}, 64'd1);
        din = {32'd0, $urandom};
        shift_dr(32, din, 1'b0, dout);
        chk("R5 identifier", dout, {32'd0, IDVAL});

        // R6 sample and extest
        pad_in = 5'b10011;
        shift_ir(3'b001, cap);
        shift_dr(PADS + 3, 64'd0, 1'b0, dout);
        chk("R6 sample capture", dout, {56'd0, 5'b10011, RSV});
        pad_in = 5'b01101;
        shift_ir(3'b000, cap);
        shift_dr(PADS + 3, 64'd0, 1'b0, dout);
        chk("R6 extest capture", dout, {56'd0, 5'b01101, RSV});

        // R7 R8 R10 user instruction 1
        shift_ir(3'b010, cap);
        chk("R7 sel1 under USER1", {63'd0, user1_sel}, 64'd1);
        chk("R7 sel2 under USER1", {63'd0, user2_sel}, 64'd0);
        @(negedge tck); #1;
        chk("R10 drck high in RTI under USER1", {63'd0, user_drck}, 64'd1);
        user1_tdo = 1'b1; user2_tdo = 1'b0;
        shift_dr(8, 64'd0, 1'b1, dout);
        chk("R8 tdo from user1", dout, 64'hFF);

        // R7 R8 user instruction 2
        shift_ir(3'b011, cap);
        chk("R7 sel2 under USER2", {63'd0, user2_sel}, 64'd1);
        chk("R7 sel1 under USER2", {63'd0, user1_sel}, 64'd0);
        user1_tdo = 1'b1; user2_tdo = 1'b0;
        shift_dr(8, 64'd0, 1'b1, dout);
        chk("R8 tdo from user2", dout, 64'h00);

        // R4 unassigned codes
        shift_ir(3'b101, cap);
        din = 64'h5A3;
        shift_dr(12, din, 1'b0, dout);
        chk("R4 code 101 bypass", dout, exp_dr(3'b101, din, 12, pad_in, 1'b0, 1'b0));
        shift_ir(3'b110, cap);
        din = 64'hC69;
        shift_dr(12, din, 1'b0, dout);
        chk("R4 code 110 bypass", dout, exp_dr(3'b110, din, 12, pad_in, 1'b0, 1'b0));

        // R1 R2: five tms-high steps from Shift-DR under USER1
        shift_ir(3'b010, cap);
        go(1); go(0); go(0);
        for (int i = 0; i < 5; i++) go(1);
        chk("R1 R2 tms reset clears sel1", {63'd0, user1_sel}, 64'd0);
        @(negedge tck); #1;
        chk("R9 oe low after tms reset", {63'd0, tdo_oe}, 64'd0);
        go(0);

        // R1: asynchronous reset in the middle of Shift-DR
        shift_ir(3'b011, cap);
        go(1); go(0); go(0);
        step(0, 1'b0, o, oe, dk, hi);
        @(negedge tck); #1;
        chk("R9 oe high before trst", {63'd0, tdo_oe}, 64'd1);
        trst_n = 1'b0; #0.5;
        chk("R1 trst clears sel2", {63'd0, user2_sel}, 64'd0);
        chk("R1 trst clears oe", {63'd0, tdo_oe}, 64'd0);
        chk("R10 trst restores drck", {63'd0, user_drck}, 64'd1);
        tms = 1'b0;
        @(posedge tck); #1; trst_n = 1'b1;
        go(0);
        shift_dr(8, 64'h81, 1'b0, dout);
        chk("R2 bypass after trst", dout, exp_dr(3'b111, 64'h81, 8, pad_in, 1'b0, 1'b0));

        // seeded random passes over every code
        for (int k = 0; k < 30; k++) begin
            logic [2:0] code;
            int n;
            code = 3'($urandom % 8);
            pad_in = PADS'($urandom);
            user1_tdo = 1'($urandom);
            user2_tdo = 1'($urandom);
            din = {$urandom, $urandom};
            n = dr_len(code);
            shift_ir(code, cap);
            chk("R3 random IR capture", {61'd0, cap}, 64'd1);
            chk("R7 random sel1", {63'd0, user1_sel}, {63'd0, code == 3'b010});
            chk("R7 random sel2", {63'd0, user2_sel}, {63'd0, code == 3'b011});
            shift_dr(n, din, (code == 3'b010) || (code == 3'b011), dout);
            chk("R4 R5 R6 R8 random scan", dout,
                exp_dr(code, din, n, pad_in, user1_tdo, user2_tdo));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule